// File: doc/BRIEF.md
# Third-Order Bitstream Decimation Filter

This block turns the single-bit output of an oversampling modulator into multi-bit samples at a lower rate. Each input bit comes with a strobe. The input rate is normally one eighth of the master clock. A one-bit counts as +1 and a zero-bit counts as −1. The stream passes through three running-sum stages at the input rate. It is then sampled once per group of N valid bits and passes through three first-difference stages at the output rate. The result is the response ((1 − z^−N)/(1 − z^−1))^3. This response has zeros at every multiple of the output rate, so any input pattern whose period divides N and whose mean is zero produces exactly zero once the filter settles.

A two-bit select chooses N from 256, 128, 64 or 32. The sum registers have a single fixed width that is large enough for the biggest N, and they wrap on overflow. The raw result is shifted right by an amount that depends on N, so every setting spans the same 15-bit twos-complement range. The single value that would overflow that range, positive full scale, is clamped. When the select changes, all filter state is cleared. The first three outputs after a change, or after reset, are suppressed because they are built from an incomplete history.

Top module: `cicDecimator`

## Requirements
- R1: While reset is asserted, and after it is released, `outValid` is low and `outSample` is zero until the first output. After release, the first output appears once exactly 4·N valid bits have been taken.
- R2: `rateSel` selects the decimation factor: 0 → N=256, 1 → N=128, 2 → N=64, 3 → N=32. In steady operation one output is produced for every N valid input bits.
- R3: A one-bit counts as +1 and a zero-bit as −1. Once the filter settles, a constant stream of ones gives +16383 (15'h3FFF, clamped from +16384) and a constant stream of zeros gives −16384 (15'h4000), at every N.
- R4: The raw filter value is shifted right by 3·log2(N) − 14. For a repeating pattern whose period divides N and whose fraction of ones is p, the settled output is (2p − 1)·16384.
- R5: A repeating pattern whose period divides N and that has as many ones as zeros (for example 1010… or 1100…) settles to exactly 0.
- R6: In a cycle where `rateSel` differs from its value in the previous cycle, all filter state is cleared and that cycle's input bit is dropped. No output appears until 4·N further valid bits have been taken, and the output then has the new N's settled value.
- R7: `outValid` is a one-cycle pulse. It is high in the cycle after the bit that completes a group, and `outSample` changes only together with `outValid`.
- R8: The value on `bitIn` in cycles where `bitValid` is low has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| bitIn | input | 1 | Modulator bit: 1 counts as +1, 0 counts as −1 |
| bitValid | input | 1 | High when bitIn carries a new bit |
| rateSel | input | 2 | Decimation select: 0→256, 1→128, 2→64, 3→32 |
| outSample | output | 15 | Filtered twos-complement sample |
| outValid | output | 1 | One-cycle pulse when outSample is new |

## Verification
The bench drives periodic patterns of different densities at each of the four factors and compares the settled value with (2p − 1)·16384. A wrong shift, or a wrong mapping of the input bit, shows up as a scaled or inverted result. A stream of all ones checks the clamp: without it the output would wrap to −16384. Zero-mean patterns check the nulls, and any leftover value there points to a wrong differential delay. After each change of rate and after a reset, the bench counts input bits up to the first output. A design that skipped the flush, or discarded the wrong number of outputs, would deliver stale or partly settled values early. Bits with `bitValid` low are driven with the inverted value of the pattern bit, so a design that sampled them would leave the full-scale result.

// File: rtl/cicDecimPkg.sv
package cicDecimPkg;

  typedef struct packed {
    logic flush;    // clear every stage
    logic integEn;  // accept one input bit
    logic dump;     // last bit of a group: run the comb stages
    logic emit;     // dump whose result is delivered
  } cicStrobeT;

  // log2 of the decimation factor for a select code
  function automatic int unsigned factorLog(input int unsigned maxLog, input int unsigned sel);
    return maxLog - sel;
  endfunction

endpackage

// File: rtl/cicCtrl.sv
module cicCtrl
  import cicDecimPkg::*;
#(
  parameter int MAX_LOG2 = 8,
  parameter int SEL_W    = 2,
  parameter int SETTLE   = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bitValid,
  input  logic [SEL_W-1:0] rateSel,
  output cicStrobeT        strobe
);

  localparam int DISC_W = $clog2(SETTLE + 1);

  logic [SEL_W-1:0]    lastSel;
  logic [MAX_LOG2-1:0] phase;
  logic [DISC_W-1:0]   discardCnt;
  logic [MAX_LOG2:0]   groupSize;
  logic [MAX_LOG2:0]   groupLast;

  always_comb begin
    groupSize      = (MAX_LOG2+1)'(1) << factorLog(MAX_LOG2, int'(rateSel));
    groupLast      = groupSize - (MAX_LOG2+1)'(1);
    strobe.flush   = (rateSel != lastSel);
    strobe.integEn = bitValid && !strobe.flush;
    strobe.dump    = strobe.integEn && (phase == groupLast[MAX_LOG2-1:0]);
    strobe.emit    = strobe.dump && (discardCnt == '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lastSel    <= '0;
      phase      <= '0;
      discardCnt <= DISC_W'(SETTLE);
    end else begin
      lastSel <= rateSel;
      if (strobe.flush) begin
        phase      <= '0;
        discardCnt <= DISC_W'(SETTLE);
      end else if (strobe.integEn) begin
        phase <= strobe.dump ? '0 : phase + 1'b1;
        if (strobe.dump && discardCnt != '0)
          discardCnt <= discardCnt - 1'b1;
      end
    end
  end

endmodule

// File: rtl/cicPath.sv
module cicPath
  import cicDecimPkg::*;
#(
  parameter int MAX_LOG2 = 8,
  parameter int OUT_W    = 15,
  parameter int SEL_W    = 2,
  parameter int ORDER    = 3
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    bitIn,
  input  logic [SEL_W-1:0]        rateSel,
  input  cicStrobeT               strobe,
  output logic signed [OUT_W-1:0] outSample,
  output logic                    outValid
);

  localparam int ACC_W = ORDER * MAX_LOG2 + 2;
  localparam int SH_W  = $clog2(ORDER * MAX_LOG2 + 1);
  localparam logic signed [ACC_W-1:0] POS_LIM = ACC_W'((2 ** (OUT_W - 1)) - 1);
  localparam logic signed [ACC_W-1:0] NEG_LIM = ~POS_LIM;

  logic signed [ACC_W-1:0] inVal;
  logic signed [ACC_W-1:0] integ   [ORDER];
  logic signed [ACC_W-1:0] combIn  [ORDER+1];
  logic signed [ACC_W-1:0] combDly [ORDER];
  logic signed [ACC_W-1:0] scaled;
  logic signed [OUT_W-1:0] clamped;
  logic [SH_W-1:0]         shiftAmt;

  assign inVal = bitIn ? ACC_W'(1) : '1;

  // running-sum stages, each fed by the previous stage's register
  for (genvar g = 0; g < ORDER; g++) begin : gInteg
    logic signed [ACC_W-1:0] stageIn;
    if (g == 0) begin : gFirst
      assign stageIn = inVal;
    end else begin : gNext
      assign stageIn = integ[g-1];
    end
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)               integ[g] <= '0;
      else if (strobe.flush)   integ[g] <= '0;
      else if (strobe.integEn) integ[g] <= integ[g] + stageIn;
    end
  end

  assign combIn[0] = integ[ORDER-1];

  // first-difference stages at the group rate
  for (genvar g = 0; g < ORDER; g++) begin : gComb
    assign combIn[g+1] = combIn[g] - combDly[g];
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)             combDly[g] <= '0;
      else if (strobe.flush) combDly[g] <= '0;
      else if (strobe.dump)  combDly[g] <= combIn[g];
    end
  end

  always_comb begin
    shiftAmt = SH_W'(ORDER * factorLog(MAX_LOG2, int'(rateSel))) - SH_W'(OUT_W - 1);
    scaled   = combIn[ORDER] >>> shiftAmt;
    if (scaled > POS_LIM)      clamped = POS_LIM[OUT_W-1:0];
    else if (scaled < NEG_LIM) clamped = NEG_LIM[OUT_W-1:0];
    else                       clamped = scaled[OUT_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outSample <= '0;
      outValid  <= 1'b0;
    end else begin
      outValid <= strobe.emit;
      if (strobe.emit) outSample <= clamped;
    end
  end

endmodule

// File: rtl/cicDecimator.sv
module cicDecimator
  import cicDecimPkg::*;
#(
  parameter int MAX_LOG2 = 8,
  parameter int OUT_W    = 15,
  parameter int SEL_W    = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    bitIn,
  input  logic                    bitValid,
  input  logic [SEL_W-1:0]        rateSel,
  output logic signed [OUT_W-1:0] outSample,
  output logic                    outValid
);

  cicStrobeT strobe;

  cicCtrl #(.MAX_LOG2(MAX_LOG2), .SEL_W(SEL_W), .SETTLE(3)) uCtrl (
    .clk(clk), .rstN(rstN), .bitValid(bitValid), .rateSel(rateSel), .strobe(strobe)
  );

  cicPath #(.MAX_LOG2(MAX_LOG2), .OUT_W(OUT_W), .SEL_W(SEL_W), .ORDER(3)) uPath (
    .clk(clk), .rstN(rstN), .bitIn(bitIn), .rateSel(rateSel), .strobe(strobe),
    .outSample(outSample), .outValid(outValid)
  );

endmodule

// File: rtl/cicDecimChecker.sv
module cicDecimChecker #(
  parameter int MAX_LOG2 = 8,
  parameter int OUT_W    = 15,
  parameter int SEL_W    = 2
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    bitValid,
  input logic [SEL_W-1:0]        rateSel,
  input logic signed [OUT_W-1:0] outSample,
  input logic                    outValid
);

  localparam int CNT_W = MAX_LOG2 + 3;

  logic [SEL_W-1:0] prevSel;
  logic [CNT_W-1:0] bitCnt;
  logic [CNT_W-1:0] groupLen;
  logic             seenOut;

  assign groupLen = CNT_W'(1) << (MAX_LOG2 - int'(rateSel));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevSel <= '0;
      bitCnt  <= '0;
      seenOut <= 1'b0;
    end else begin
      prevSel <= rateSel;
      if (rateSel != prevSel) begin
        bitCnt  <= '0;
        seenOut <= 1'b0;
      end else if (outValid) begin
        seenOut <= 1'b1;
        bitCnt  <= bitValid ? CNT_W'(1) : '0;
      end else if (bitValid) begin
        bitCnt <= bitCnt + 1'b1;
      end
    end
  end

  assert_group_len_R2: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && seenOut) |-> (bitCnt == groupLen));

  assert_first_late_R6: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !seenOut) |-> (bitCnt == (groupLen << 2)));

  assert_rate_quiet_R6: assert property (@(posedge clk) disable iff (!rstN)
    (rateSel != $past(rateSel)) |=> !outValid);

  assert_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    outValid |=> !outValid);

  assert_after_bit_R7: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(bitValid));

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> $stable(outSample));

endmodule

bind cicDecimator cicDecimChecker #(.MAX_LOG2(MAX_LOG2), .OUT_W(OUT_W), .SEL_W(SEL_W)) uChk (
  .clk(clk), .rstN(rstN), .bitValid(bitValid), .rateSel(rateSel),
  .outSample(outSample), .outValid(outValid)
);

// File: tb/sim_cicDecimator.sv
`timescale 1ns/1ps
module sim_cicDecimator;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bitIn = 1'b0;
  logic bitValid = 1'b0;
  logic [1:0] rateSel = 2'd0;
  logic signed [14:0] outSample;
  logic outValid;

  cicDecimator u0 (
    .clk(clk), .rstN(rstN), .bitIn(bitIn), .bitValid(bitValid),
    .rateSel(rateSel), .outSample(outSample), .outValid(outValid)
  );

  always #10 clk = ~clk;

  // {rateSel, 8-bit repeating pattern, expected settled value}
  localparam int NV = 10;
  localparam logic [25:0] VEC [NV] = '{
    {2'd0, 8'hFF, 16'h3FFF},  // all ones, clamped
    {2'd0, 8'h00, 16'hC000},  // all zeros
    {2'd1, 8'hAA, 16'h0000},  // 1010 null
    {2'd2, 8'h33, 16'h0000},  // 1100 null
    {2'd3, 8'h77, 16'h2000},  // 3/4 ones
    {2'd3, 8'h11, 16'hE000},  // 1/4 ones
    {2'd2, 8'h1F, 16'h1000},  // 5/8 ones
    {2'd1, 8'h07, 16'hF000},  // 3/8 ones
    {2'd0, 8'h7F, 16'h3000},  // 7/8 ones
    {2'd3, 8'hFF, 16'h3FFF}   // all ones at N=32
  };

  int checks = 0;
  int fails = 0;
  int outCount = 0;
  int bitsSent = 0;
  int bitsAt [6];
  int idx = 0;
  logic [7:0] pat = 8'hFF;
  logic signed [14:0] lastOut = '0;
  logic prevValid = 1'b0;
  logic pulseErr = 1'b0;

  always @(negedge clk) begin
    if (outValid) begin
      if (outCount < 6) bitsAt[outCount] = bitsSent;
      outCount++;
      lastOut = outSample;
      if (prevValid) pulseErr = 1'b1;
    end
    prevValid = outValid;
  end

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic sendBit();
    @(negedge clk);
    bitIn = pat[idx % 8];
    bitValid = 1'b1;
    bitsSent++;
    idx++;
    @(negedge clk);
    bitValid = 1'b0;
    bitIn = ~bitIn;  // junk on idle cycles (R8)
  endtask

  task automatic restartCount();
    outCount = 0;
    bitsSent = 0;
    idx = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [1:0] prevSel;
    repeat (3) @(negedge clk);
    check(outValid == 1'b0 && outSample == 15'sd0, "R1 reset state",
          int'(outSample), 0);
    rstN = 1'b1;
    prevSel = 2'd0;

    for (int v = 0; v < NV; v++) begin
      logic [1:0] sel;
      logic signed [14:0] expv;
      logic fresh;
      int n;
      string tag;
      sel   = VEC[v][25:24];
      expv  = VEC[v][14:0];
      fresh = (v == 0) || (sel != prevSel);
      n     = 256 >> sel;
      @(negedge clk);
      rateSel = sel;
      pat = VEC[v][23:16];
      repeat (3) @(negedge clk);
      restartCount();
      while (outCount < 5) sendBit();
      if (pat == 8'hFF || pat == 8'h00) tag = "R3 R8 full scale";
      else if (expv == 15'sd0)          tag = "R5 null pattern";
      else                              tag = "R4 density scaling";
      check(lastOut == expv, tag, int'(lastOut), int'(expv));
      if (fresh) begin
        check(bitsAt[0] == 4 * n, "R6 bits to first output", bitsAt[0], 4 * n);
        check(bitsAt[1] - bitsAt[0] == n, "R2 bits per output",
              bitsAt[1] - bitsAt[0], n);
      end
      prevSel = sel;
    end

    // reset in the middle of a group
    @(negedge clk);
    rateSel = 2'd3;
    pat = 8'hFF;
    repeat (3) @(negedge clk);
    restartCount();
    repeat (50) sendBit();
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check(outValid == 1'b0 && outSample == 15'sd0, "R1 mid-run reset clears output",
          int'(outSample), 0);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    restartCount();
    while (outCount < 1) sendBit();
    check(bitsAt[0] == 128, "R1 first output after reset", bitsAt[0], 128);
    check(lastOut == 15'sd16383, "R1 settled value after reset", int'(lastOut), 16383);

    check(!pulseErr, "R7 single-cycle valid", int'(pulseErr), 0);

    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule